// File: doc/BRIEF.md
# Redundant Reference Switchover Controller

This block decides which of two redundant timing references, primary or secondary, feeds a downstream clock synchronizer. It also keeps track of the synchronizer's operating mode: locked to a reference, holding over, or running free. Its inputs are a loss-of-signal flag for each reference, the synchronizer lock indicator, and a few control fields held in a register bank elsewhere. Those fields are the requested operating mode, a manual reference choice, an enable for autonomous hardware action, and a policy bit.

When autonomous action is enabled and the reference in use disappears, the policy bit sets the reaction. Under the switch policy the block moves to the other reference, as long as that reference is present. Under the hold policy it enters holdover. When autonomous action is disabled, software's manual choice alone sets the reference, and loss flags cause no reaction. Every output is registered. The active-reference indication changes on the same edge as the internal selection.

Top module: `ref_switchover_ctrl`

## Requirements
- R1: A synchronous active-high reset makes active_ref 0 (primary), holdover 0, op_mode 2'b00 (normal) and alarm 4'b0000 after the edge.
- R2: The mode_cfg encoding is 2'b00 normal, 2'b01 forced holdover, 2'b10 free-run; 2'b11 acts as normal. After an edge with 2'b01, holdover is 1 and op_mode is 2'b01. After an edge with 2'b10, holdover is 0 and op_mode is 2'b10. In normal mode op_mode mirrors holdover (2'b01 when holding, else 2'b00).
- R3: With hw_auto_en 0, active_ref equals the manual_sel value of the previous edge (0 primary, 1 secondary). Loss flags then cause no switch and no holdover.
- R4: Take hw_auto_en 1, hw_hold_policy 0, normal mode and no holdover. If the active reference's loss flag is set and the other's is clear, active_ref inverts at the next edge and holdover stays 0.
- R5: Under the same conditions as R4, if both loss flags are set, the block enters holdover at the next edge and active_ref does not change.
- R6: Take hw_auto_en 1, hw_hold_policy 1, normal mode and no holdover. A set loss flag on the active reference causes holdover at the next edge, and active_ref does not change.
- R7: Holdover is left only on an edge where mode_cfg is normal and the target reference is present. The target is the current reference when hw_auto_en is 1, and manual_sel otherwise.
- R8: alarm[3] is pri_los and alarm[2] is sec_los, each as sampled at the previous edge. alarm[1] equals holdover. alarm[0] is the inverse of pll_locked at the previous edge.
- R9: With hw_auto_en 1 and the active reference present, manual_sel has no effect on active_ref.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pri_los | input | 1 | Primary reference loss of signal |
| sec_los | input | 1 | Secondary reference loss of signal |
| pll_locked | input | 1 | Synchronizer lock indicator |
| mode_cfg | input | 2 | Requested operating mode |
| manual_sel | input | 1 | Software reference choice (0 primary, 1 secondary) |
| hw_auto_en | input | 1 | Enables autonomous reaction to reference loss |
| hw_hold_policy | input | 1 | 1: hold over on loss, 0: switch to the other reference |
| active_ref | output | 1 | Reference in use (0 primary, 1 secondary) |
| holdover | output | 1 | Holdover state |
| op_mode | output | 2 | Reported operating mode |
| alarm | output | 4 | {primary lost, secondary lost, holdover, unlocked} |

## Verification
The bench targets loss of both references under the switch policy. A design that got this wrong would bounce between two dead references on every edge instead of holding over. It also checks that holdover is not left while the target reference is still missing or the mode field is not normal, and that manual_sel is ignored while hardware owns the selection. An error in either would show up as a premature exit or as an unexpected switch. A sweep over every combination of inputs, repeated in several orders so that each combination is met from different states, compares all outputs with an arithmetic model. That sweep reaches forced holdover, free-run, the reserved mode code and the transitions between them.

// File: rtl/ref_switchover_ctrl.sv
module ref_switchover_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       pri_los,
  input  logic       sec_los,
  input  logic       pll_locked,
  input  logic [1:0] mode_cfg,
  input  logic       manual_sel,
  input  logic       hw_auto_en,
  input  logic       hw_hold_policy,
  output logic       active_ref,
  output logic       holdover,
  output logic [1:0] op_mode,
  output logic [3:0] alarm
);
  localparam logic [1:0] MODE_HOLD = 2'b01;
  localparam logic [1:0] MODE_FREE = 2'b10;

  logic sel_q, hold_q, free_q, pri_q, sec_q, unlk_q;
  logic sel_d, hold_d;

  wire cur_los = sel_q ? sec_los : pri_los;
  wire oth_los = sel_q ? pri_los : sec_los;
  wire tgt_sel = hw_auto_en ? sel_q : manual_sel;
  wire tgt_los = tgt_sel ? sec_los : pri_los;

  always_comb begin
    sel_d  = tgt_sel;
    hold_d = hold_q;
    if (mode_cfg == MODE_FREE) begin
      hold_d = 1'b0;
    end else if (mode_cfg == MODE_HOLD) begin
      hold_d = 1'b1;
    end else if (hold_q) begin
      hold_d = tgt_los;
    end else if (hw_auto_en && cur_los) begin
      if (hw_hold_policy || oth_los) hold_d = 1'b1;
      else                           sel_d  = ~sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      hold_q <= 1'b0;
      free_q <= 1'b0;
      pri_q  <= 1'b0;
      sec_q  <= 1'b0;
      unlk_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      hold_q <= hold_d;
      free_q <= (mode_cfg == MODE_FREE);
      pri_q  <= pri_los;
      sec_q  <= sec_los;
      unlk_q <= ~pll_locked;
    end
  end

  assign active_ref = sel_q;
  assign holdover   = hold_q;
  assign op_mode    = free_q ? MODE_FREE : (hold_q ? MODE_HOLD : 2'b00);
  assign alarm      = {pri_q, sec_q, hold_q, unlk_q};
endmodule

module ref_switchover_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pri_los,
  input logic       sec_los,
  input logic       pll_locked,
  input logic [1:0] mode_cfg,
  input logic       manual_sel,
  input logic       hw_auto_en,
  input logic       hw_hold_policy,
  input logic       active_ref,
  input logic       holdover,
  input logic [1:0] op_mode,
  input logic [3:0] alarm
);
  wire act_lost = active_ref ? sec_los : pri_los;
  wire alt_lost = active_ref ? pri_los : sec_los;
  wire run_auto = hw_auto_en && !holdover && (mode_cfg == 2'b00 || mode_cfg == 2'b11);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (active_ref == 1'b0 && !holdover && op_mode == 2'b00 && alarm == 4'b0000));
  // R2
  forced_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mode_cfg == 2'b01 |=> (holdover && op_mode == 2'b01));
  // R2
  free_run_chk: assert property (@(posedge clk) disable iff (rst)
    mode_cfg == 2'b10 |=> (!holdover && op_mode == 2'b10));
  // R3
  manual_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !hw_auto_en |=> active_ref == $past(manual_sel));
  // R4
  switch_over_chk: assert property (@(posedge clk) disable iff (rst)
    (run_auto && !hw_hold_policy && act_lost && !alt_lost) |=> (active_ref != $past(active_ref) && !holdover));
  // R5
  both_lost_chk: assert property (@(posedge clk) disable iff (rst)
    (run_auto && !hw_hold_policy && act_lost && alt_lost) |=> (holdover && $stable(active_ref)));
  // R6
  hold_policy_chk: assert property (@(posedge clk) disable iff (rst)
    (run_auto && hw_hold_policy && act_lost) |=> (holdover && $stable(active_ref)));
  // R7
  hold_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (holdover && hw_auto_en && act_lost && mode_cfg != 2'b10) |=> holdover);
  // R8
  alarm_map_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (alarm[3] == $past(pri_los) && alarm[2] == $past(sec_los) &&
              alarm[1] == holdover && alarm[0] == !$past(pll_locked)));
  // R9
  manual_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_auto_en && !act_lost && mode_cfg != 2'b10) |=> $stable(active_ref));
endmodule

bind ref_switchover_ctrl ref_switchover_ctrl_chk u_chk (.*);

// File: tb/ref_switchover_ctrl_bench.sv
module ref_switchover_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pri_los = 1'b0, sec_los = 1'b0, pll_locked = 1'b1;
  logic [1:0] mode_cfg = 2'b00;
  logic manual_sel = 1'b0, hw_auto_en = 1'b0, hw_hold_policy = 1'b0;
  logic active_ref, holdover;
  logic [1:0] op_mode;
  logic [3:0] alarm;

  int checks = 0;
  int fails = 0;

  logic m_sel, m_hold, m_free, m_pri, m_sec, m_unlk;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_switchover_ctrl u_ref_switchover_ctrl (
    .clk(clk), .rst(rst), .pri_los(pri_los), .sec_los(sec_los),
    .pll_locked(pll_locked), .mode_cfg(mode_cfg), .manual_sel(manual_sel),
    .hw_auto_en(hw_auto_en), .hw_hold_policy(hw_hold_policy),
    .active_ref(active_ref), .holdover(holdover), .op_mode(op_mode), .alarm(alarm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected next state derived from the requirement rules
  task automatic model_edge();
    logic lost_now, lost_alt, want, want_lost, n_sel, n_hold;
    if (rst) begin
      n_sel = 0; n_hold = 0; m_free = 0; m_pri = 0; m_sec = 0; m_unlk = 0;
    end else begin
      lost_now  = m_sel ? sec_los : pri_los;
      lost_alt  = m_sel ? pri_los : sec_los;
      want      = hw_auto_en ? m_sel : manual_sel;
      want_lost = want ? sec_los : pri_los;
      n_sel  = want;
      n_hold = m_hold;
      case (mode_cfg)
        2'b10: n_hold = 0;
        2'b01: n_hold = 1;
        default:
          if (m_hold) n_hold = want_lost;
          else if (hw_auto_en && lost_now) begin
            if (hw_hold_policy || lost_alt) n_hold = 1;
            else n_sel = !m_sel;
          end
      endcase
      m_free = (mode_cfg == 2'b10);
      m_pri = pri_los; m_sec = sec_los; m_unlk = !pll_locked;
    end
    m_sel = n_sel; m_hold = n_hold;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " active_ref"}, active_ref, m_sel);
    chk({tag, " holdover"}, holdover, m_hold);
    chk({tag, " op_mode"}, op_mode, m_free ? 2 : (m_hold ? 1 : 0));
    chk({tag, " alarm"}, alarm, {m_pri, m_sec, m_hold, m_unlk});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_sel = 0; m_hold = 0; m_free = 0; m_pri = 0; m_sec = 0; m_unlk = 0;
    @(negedge clk);
    pri_los = 1; sec_los = 1; pll_locked = 0;
    step(); step();
    pri_los = 0; sec_los = 0; pll_locked = 1;
    step();
    chk("R1 active_ref", active_ref, 0);
    chk("R1 holdover", holdover, 0);
    chk("R1 op_mode", op_mode, 0);
    rst = 0;
    step();
    chk("R1 alarm", alarm, 0);

    manual_sel = 1; step();
    chk("R3 manual select", active_ref, 1);
    sec_los = 1; step();
    chk("R3 no switch on loss", active_ref, 1);
    chk("R3 no holdover on loss", holdover, 0);

    sec_los = 0; manual_sel = 0; step();
    hw_auto_en = 1; step();
    manual_sel = 1; step();
    chk("R9 manual ignored", active_ref, 0);
    pri_los = 1; step();
    chk("R4 switched to secondary", active_ref, 1);
    chk("R4 no holdover", holdover, 0);
    sec_los = 1; step();
    chk("R5 holdover on double loss", holdover, 1);
    chk("R5 ref unchanged", active_ref, 1);
    chk("R8 alarm both lost", alarm, 4'b1110);
    chk("R2 op_mode in holdover", op_mode, 1);
    step();
    chk("R7 stays while target lost", holdover, 1);
    sec_los = 0; step();
    chk("R7 exit when target back", holdover, 0);
    chk("R7 ref kept", active_ref, 1);

    hw_hold_policy = 1; pri_los = 0; step();
    sec_los = 1; step();
    chk("R6 holdover on loss", holdover, 1);
    chk("R6 ref unchanged", active_ref, 1);
    sec_los = 0; mode_cfg = 2'b01; step();
    chk("R7 forced mode keeps holdover", holdover, 1);
    chk("R2 forced op_mode", op_mode, 1);
    mode_cfg = 2'b10; step();
    chk("R2 free-run op_mode", op_mode, 2);
    chk("R2 free-run clears holdover", holdover, 0);
    mode_cfg = 2'b11; step();
    chk("R2 reserved acts normal", op_mode, 0);
    pll_locked = 0; step();
    chk("R8 unlocked alarm", alarm, 4'b0001);
    pll_locked = 1;

    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 256; c++) begin
        int v;
        v = (c * (2 * p * 40 + 1) + p * 77) % 256;
        pri_los = v[0]; sec_los = v[1]; pll_locked = v[2];
        mode_cfg = v[4:3]; manual_sel = v[5]; hw_auto_en = v[6];
        hw_hold_policy = v[7];
        step();
        check_all("sweep R2 R3 R4 R5 R6 R7 R8 R9");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule